// File: doc/BRIEF.md
# Bidirectional-mode serial EEPROM protocol engine

This block is the two-wire read/write engine of a 128-byte serial memory. It handles the bus only while the mode flag shows the bidirectional mode; in that mode it watches the synchronized clock and data lines for START and STOP, acknowledges a device address whose upper nibble is 1010, and then runs byte writes, page writes, random reads (a word address, a repeated START, a read address) and sequential reads. The memory sits inside the block and is also written through a one-cycle write port that the top brings out.

Write data is gathered in a 16-entry page buffer. Nothing reaches the memory until a STOP ends the write. The buffer is then drained during a busy period whose length in system clocks is a parameter. During that period the block leaves its address unacknowledged. The write-enable level is sampled at that STOP: when it is low, the buffer is thrown away and no busy period follows.

The memory write port is a plain strobe with no ready. It carries one beat for each buffered byte, in rising page-offset order, and the receiver must take every beat in the cycle it appears. The data line is modelled as an active-high pull-down enable. The bus wire is the AND of the master's level and the inverse of that enable.

Top module: `ddc_eeprom_bidir`

## Requirements
- R1: A START is a falling data line while the clock is high, and a STOP is a rising data line while the clock is high. Bits clocked in before any START are ignored and draw no acknowledge.
- R2: The first byte after a START is taken MSB first on clock rising edges. Bits 7:4 equal to 1010 and no write cycle running give an acknowledge: the data line is pulled low through the ninth clock. Bits 3:1 are ignored, and bit 0 selects read (1) or write (0). Any other value leaves the line released until the next START.
- R3: After a write address, the next byte sets the 7-bit word address, with its MSB ignored. Every following byte is a data byte, and each one is acknowledged.
- R4: Data bytes land in a 16-entry buffer at the low four address bits, which then step with wrap inside the page, so the 17th and later bytes overwrite earlier ones. After the STOP, the write port gives exactly one beat for each occupied offset, in rising offset order, all within one page.
- R5: A write cycle starts only at a STOP that ends a write holding buffered data, and lasts WR_CYCLES clocks. During it, the device address is not acknowledged.
- R6: If the write-enable input is low at that STOP, data bytes are still acknowledged, but the buffer is discarded, the memory is left unchanged and no write cycle starts.
- R7: A read starts at the current address and sends MSB first. After each byte the address steps by one with wrap from 0x7F to 0x00. A master acknowledge continues the read, and a master NACK ends it.
- R8: A repeated START before any STOP discards the buffered write data. A word address followed by a repeated START therefore sets the address for a random read without writing.
- R9: While the mode flag is low, the engine stays idle and the pull-down is released from the next clock on.
- R10: The pull-down enable only turns on while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data line level |
| wr_en_i | input | 1 | Write-enable level, sampled at STOP |
| bidir_i | input | 1 | Mode flag, high in bidirectional mode |
| sda_drive_low_o | output | 1 | Pull-down enable for the data line |
| mem_wr_valid_o | output | 1 | Memory write strobe |
| mem_wr_addr_o | output | 7 | Memory write address |
| mem_wr_data_o | output | 8 | Memory write data |

## Verification
Four things are checked on every clock: the pull-down never turns on with the bus clock high, it is released once the mode flag drops, a write cycle begins only on the clock that sees a STOP, and no byte is acknowledged while that cycle runs. Consecutive write beats are also checked to stay in a single page. Only the directed scenarios can show the rest. That covers address matching with the ignored bits, the order in which overwritten page bytes end up, and address wrap in reads. It also covers the rule that an inhibited or aborted write leaves memory unchanged, and the length of the busy window as seen from the bus.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } bus_st_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_WADDR,
    K_WDATA,
    K_READ
  } byte_kind_t;
endpackage

// File: rtl/ddc_bus_edges.sv
module ddc_bus_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;
endmodule

// File: rtl/ddc_page_buf.sv
module ddc_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int PAGE_CNT   = 8,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int GW = $clog2(PAGE_CNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          wr_i,
  input  logic [PW-1:0] wr_off_i,
  input  logic [GW-1:0] wr_page_i,
  input  logic [7:0]    wr_data_i,
  input  logic [PW-1:0] rd_off_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  output logic          any_valid_o,
  output logic [GW-1:0] page_o
);
  logic [7:0]            slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ    <= '0;
      page_o <= '0;
    end else if (clear_i) begin
      occ <= '0;
    end else if (wr_i) begin
      occ[wr_off_i] <= 1'b1;
      page_o        <= wr_page_i;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_i) slot[wr_off_i] <= wr_data_i;
  end

  assign rd_data_o   = slot[rd_off_i];
  assign rd_valid_o  = occ[rd_off_i];
  assign any_valid_o = |occ;
endmodule

// File: rtl/ddc_commit.sv
module ddc_commit #(
  parameter int PAGE_BYTES = 16,
  parameter int PAGE_CNT   = 8,
  parameter int WR_CYCLES  = 1000,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int GW = $clog2(PAGE_CNT),
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [GW-1:0]    page_i,
  input  logic [7:0]       rd_data_i,
  input  logic             rd_valid_i,
  output logic [PW-1:0]    rd_off_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             wr_valid_o,
  output logic [GW+PW-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (!busy_o) begin
      if (go_i) begin
        busy_o <= 1'b1;
        cnt    <= '0;
      end
    end else if (cnt == CW'(WR_CYCLES - 1)) begin
      busy_o <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done_o     = busy_o && (cnt == CW'(WR_CYCLES - 1));
  assign rd_off_o   = cnt[PW-1:0];
  assign wr_valid_o = busy_o && (cnt < CW'(PAGE_BYTES)) && rd_valid_i;
  assign wr_addr_o  = {page_i, cnt[PW-1:0]};
  assign wr_data_o  = rd_data_i;

  // R4
  page_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && $past(wr_valid_o)) |-> (wr_addr_o[GW+PW-1:PW] == $past(wr_addr_o[GW+PW-1:PW])));
endmodule

// File: rtl/ddc_eeprom_bidir.sv
module ddc_eeprom_bidir #(
  parameter int          MEM_DEPTH  = 128,
  parameter int          PAGE_BYTES = 16,
  parameter int          WR_CYCLES  = 1000,
  parameter logic [3:0]  DEV_ID     = 4'b1010,
  localparam int AW = $clog2(MEM_DEPTH),
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int GW = AW - PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          wr_en_i,
  input  logic          bidir_i,
  output logic          sda_drive_low_o,
  output logic          mem_wr_valid_o,
  output logic [AW-1:0] mem_wr_addr_o,
  output logic [7:0]    mem_wr_data_o
);
  import ddc_pkg::*;

  logic start_det, stop_det, rise, fall;
  bus_st_t    state;
  byte_kind_t kind;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [AW-1:0] addr;
  logic          mack;
  logic [7:0]    mem [MEM_DEPTH];

  logic          buf_wr, buf_clr, any_valid, rd_valid, busy, done, commit_go;
  logic [PW-1:0] rd_off;
  logic [GW-1:0] page;
  logic [7:0]    rd_data;

  ddc_bus_edges u_edges (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_det), .stop_o(stop_det), .rise_o(rise), .fall_o(fall)
  );

  ddc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .PAGE_CNT(1 << GW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear_i(buf_clr), .wr_i(buf_wr),
    .wr_off_i(addr[PW-1:0]), .wr_page_i(addr[AW-1:PW]), .wr_data_i(shreg),
    .rd_off_i(rd_off), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .any_valid_o(any_valid), .page_o(page)
  );

  ddc_commit #(.PAGE_BYTES(PAGE_BYTES), .PAGE_CNT(1 << GW), .WR_CYCLES(WR_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n), .go_i(commit_go), .page_i(page),
    .rd_data_i(rd_data), .rd_valid_i(rd_valid), .rd_off_o(rd_off),
    .busy_o(busy), .done_o(done), .wr_valid_o(mem_wr_valid_o),
    .wr_addr_o(mem_wr_addr_o), .wr_data_o(mem_wr_data_o)
  );

  // bus-side strobes into the buffer and the commit engine
  logic bus_live;
  assign bus_live  = bidir_i && !start_det && !stop_det;
  assign buf_wr    = bus_live && state == ST_RX && fall && bitcnt == 4'd8 && kind == K_WDATA;
  assign commit_go = bidir_i && stop_det && any_valid && !busy && wr_en_i;
  assign buf_clr   = done || (bidir_i && !busy && (start_det || (stop_det && !wr_en_i)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (mem_wr_valid_o) begin
      mem[mem_wr_addr_o] <= mem_wr_data_o;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= ST_IDLE;
      kind            <= K_DEV;
      bitcnt          <= '0;
      shreg           <= '0;
      addr            <= '0;
      mack            <= 1'b0;
      sda_drive_low_o <= 1'b0;
    end else if (!bidir_i) begin
      state           <= ST_IDLE;
      bitcnt          <= '0;
      sda_drive_low_o <= 1'b0;
    end else if (start_det) begin
      state           <= ST_RX;
      kind            <= K_DEV;
      bitcnt          <= '0;
      sda_drive_low_o <= 1'b0;
    end else if (stop_det) begin
      state           <= ST_IDLE;
      sda_drive_low_o <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_i};
            bitcnt <= bitcnt + 1'b1;
          end else if (fall && bitcnt == 4'd8) begin
            unique case (kind)
              K_DEV: begin
                if (shreg[7:4] == DEV_ID && !busy) begin
                  sda_drive_low_o <= 1'b1;
                  state           <= ST_ACK;
                  kind            <= shreg[0] ? K_READ : K_WADDR;
                end else begin
                  state <= ST_IDLE;
                end
              end
              K_WADDR: begin
                addr            <= shreg[AW-1:0];
                kind            <= K_WDATA;
                sda_drive_low_o <= 1'b1;
                state           <= ST_ACK;
              end
              K_WDATA: begin
                addr            <= {addr[AW-1:PW], PW'(addr[PW-1:0] + 1'b1)};
                sda_drive_low_o <= 1'b1;
                state           <= ST_ACK;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_ACK: begin
          if (fall) begin
            bitcnt <= '0;
            if (kind == K_READ) begin
              state           <= ST_TX;
              shreg           <= mem[addr];
              sda_drive_low_o <= ~mem[addr][7];
            end else begin
              state           <= ST_RX;
              sda_drive_low_o <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (fall) begin
            if (bitcnt < 4'd8) begin
              shreg           <= {shreg[6:0], 1'b0};
              sda_drive_low_o <= ~shreg[6];
            end else begin
              sda_drive_low_o <= 1'b0;
              addr            <= addr + 1'b1;
              state           <= ST_TXACK;
            end
          end
        end
        ST_TXACK: begin
          if (rise) begin
            mack <= ~sda_i;
          end else if (fall) begin
            if (mack) begin
              state           <= ST_TX;
              bitcnt          <= '0;
              shreg           <= mem[addr];
              sda_drive_low_o <= ~mem[addr][7];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  drive_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low_o) |-> !scl_i);

  // R9
  mode_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bidir_i |=> !sda_drive_low_o);

  // R5
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  // R5
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> state != ST_ACK);
endmodule

// File: tb/ddc_eeprom_bidir_test.sv
module ddc_eeprom_bidir_test;
  localparam int WR_CYC = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wr_en = 1'b1;
  logic bidir = 1'b0;
  logic drive, wv;
  logic [6:0] wa;
  logic [7:0] wd;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [6:0] last_a = '0;
  logic [7:0] last_d = '0;
  logic prev_drive = 1'b0;
  int r10_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~drive;

  ddc_eeprom_bidir #(.WR_CYCLES(WR_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .wr_en_i(wr_en), .bidir_i(bidir), .sda_drive_low_o(drive),
    .mem_wr_valid_o(wv), .mem_wr_addr_o(wa), .mem_wr_data_o(wd)
  );

  always @(negedge clk) begin
    if (wv) begin
      wr_cnt <= wr_cnt + 1;
      last_a <= wa;
      last_d <= wd;
    end
    if (drive && !prev_drive && scl) r10_bad <= r10_bad + 1;
    prev_drive <= drive;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(3);
    scl = 1'b1; tick(5);
    sda_m = 1'b0; tick(5);
    scl = 1'b0; tick(3);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(3);
    scl = 1'b1; tick(5);
    sda_m = 1'b1; tick(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(3);
      scl = 1'b1; tick(5);
      scl = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(3);
    scl = 1'b1; tick(2);
    ack = (sda_line == 1'b0);
    tick(3);
    scl = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input bit master_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(3);
      scl = 1'b1; tick(2);
      b = {b[6:0], sda_line};
      tick(3);
      scl = 1'b0; tick(2);
    end
    sda_m = master_ack ? 1'b0 : 1'b1; tick(3);
    scl = 1'b1; tick(5);
    scl = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  task automatic write_one(input logic [6:0] a, input logic [7:0] d);
    bit ack;
    bus_start;
    send_byte(8'hA0, ack);
    send_byte({1'b0, a}, ack);
    send_byte(d, ack);
    bus_stop;
    tick(WR_CYC + 50);
  endtask

  task automatic t_reset;
    check(drive == 1'b0, "R9 reset pull-down", int'(drive), 0);
    check(wv == 1'b0, "R4 reset write strobe", int'(wv), 0);
  endtask

  task automatic t_mode_off;
    bit ack;
    bus_start;
    send_byte(8'hA0, ack);
    check(!ack, "R9 no ack with mode flag low", int'(ack), 0);
    bus_stop;
  endtask

  task automatic t_no_start;
    bit ack;
    send_byte(8'hA0, ack);
    check(!ack, "R1 no ack without START", int'(ack), 0);
    bus_stop;
  endtask

  task automatic t_addr;
    bit ack;
    bus_start;
    send_byte(8'hB0, ack);
    check(!ack, "R2 wrong device nibble", int'(ack), 0);
    bus_stop;
    bus_start;
    send_byte(8'hAE, ack);
    check(ack, "R2 ignored bits set still match", int'(ack), 1);
    send_byte(8'h40, ack);
    check(ack, "R3 word address acked", int'(ack), 1);
    bus_stop;
    tick(20);
  endtask

  task automatic t_byte_write;
    bit ack;
    int c0 = wr_cnt;
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h85, ack);
    send_byte(8'h3C, ack);
    check(ack, "R3 data byte acked", int'(ack), 1);
    tick(20);
    check(wr_cnt == c0, "R5 no write before STOP", wr_cnt - c0, 0);
    bus_stop;
    tick(30);
    check(wr_cnt == c0 + 1, "R4 one write beat", wr_cnt - c0, 1);
    check(last_a == 7'h05, "R3 word address MSB ignored", int'(last_a), 5);
    check(last_d == 8'h3C, "R4 write data", int'(last_d), 8'h3C);
    bus_start;
    send_byte(8'hA0, ack);
    check(!ack, "R5 no ack while busy", int'(ack), 0);
    bus_stop;
    tick(WR_CYC);
    bus_start;
    send_byte(8'hA0, ack);
    check(ack, "R5 ack after write cycle", int'(ack), 1);
    bus_stop;
    tick(20);
  endtask

  task automatic t_page;
    bit ack;
    int c0 = wr_cnt;
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h1E, ack);
    for (int i = 0; i < 18; i++) send_byte(8'h80 + 8'(i), ack);
    bus_stop;
    tick(40);
    check(wr_cnt == c0 + 16, "R4 sixteen beats for wrapped page", wr_cnt - c0, 16);
    check(last_a == 7'h1F, "R4 last beat highest offset", int'(last_a), 8'h1F);
    tick(WR_CYC + 50);
  endtask

  task automatic t_read;
    bit ack;
    logic [7:0] b, e;
    int c0 = wr_cnt;
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h10, ack);
    bus_start;
    send_byte(8'hA1, ack);
    check(ack, "R2 read address acked", int'(ack), 1);
    for (int k = 0; k < 16; k++) begin
      recv_byte(k != 15, b);
      e = (k <= 13) ? 8'h82 + 8'(k) : 8'h90 + 8'(k - 14);
      check(b == e, "R7 sequential read of page", int'(b), int'(e));
    end
    bus_stop;
    tick(20);
    check(wr_cnt == c0, "R8 random-read setup writes nothing", wr_cnt - c0, 0);
  endtask

  task automatic t_wrap;
    bit ack;
    logic [7:0] b;
    write_one(7'h7F, 8'h99);
    write_one(7'h00, 8'h11);
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h7F, ack);
    bus_start;
    send_byte(8'hA1, ack);
    recv_byte(1'b1, b);
    check(b == 8'h99, "R7 byte at top address", int'(b), 8'h99);
    recv_byte(1'b0, b);
    check(b == 8'h11, "R7 wrap to address zero", int'(b), 8'h11);
    bus_stop;
    bus_start;
    send_byte(8'hA1, ack);
    recv_byte(1'b0, b);
    check(b == 8'h00, "R7 current-address read", int'(b), 0);
    bus_stop;
  endtask

  task automatic t_inhibit;
    bit ack;
    logic [7:0] b;
    int c0 = wr_cnt;
    wr_en = 1'b0;
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h20, ack);
    send_byte(8'h55, ack);
    check(ack, "R6 data acked while inhibited", int'(ack), 1);
    bus_stop;
    tick(30);
    check(wr_cnt == c0, "R6 no write beats", wr_cnt - c0, 0);
    bus_start;
    send_byte(8'hA0, ack);
    check(ack, "R6 no busy period", int'(ack), 1);
    send_byte(8'h20, ack);
    bus_start;
    send_byte(8'hA1, ack);
    recv_byte(1'b0, b);
    check(b == 8'h00, "R6 memory unchanged", int'(b), 0);
    bus_stop;
    wr_en = 1'b1;
    tick(20);
  endtask

  task automatic t_restart;
    bit ack;
    logic [7:0] b;
    int c0 = wr_cnt;
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h30, ack);
    send_byte(8'h77, ack);
    bus_start;
    send_byte(8'hA1, ack);
    recv_byte(1'b0, b);
    bus_stop;
    tick(30);
    check(wr_cnt == c0, "R8 repeated START drops buffer", wr_cnt - c0, 0);
    bus_start;
    send_byte(8'hA0, ack);
    check(ack, "R8 no busy after abort", int'(ack), 1);
    send_byte(8'h30, ack);
    bus_start;
    send_byte(8'hA1, ack);
    recv_byte(1'b0, b);
    check(b == 8'h00, "R8 aborted byte not stored", int'(b), 0);
    bus_stop;
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    t_reset;
    t_mode_off;
    bidir = 1'b1;
    tick(5);
    t_no_start;
    t_addr;
    t_byte_write;
    t_page;
    t_read;
    t_wrap;
    t_inhibit;
    t_restart;
    check(r10_bad == 0, "R10 pull-down rose with clock high", r10_bad, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule